// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is the serial core of an SPI master. It moves words of 2 to 16 bits. The host side sees a small control write port, a transmit word port and a receive word port. The control port carries the enable, the two clock-mode bits, the shift-order bit and the length field. The serial side drives the serial clock, the master output line and one active-low slave select, and it samples the master input line. The half-period of the serial clock is a fixed number of system clocks, set by a parameter.

Parallel words are always right-justified: bit 0 is the least significant bit, and the most significant bit sits at position length-1. This holds for both shift orders and for every length. Any write of a transmit word while the engine is enabled and idle starts one transfer. When the last bit has been sampled, the block raises a one-cycle done pulse and a sticky complete flag. A read of the receive port clears the flag.

Clock mode, shift order and length are frozen while the engine is enabled or busy. A control write that changes the enable bit leaves all three unchanged.

Top module: `spi_shift_engine`

## Requirements
- R1: While no transfer is running, `sclk` rests at the latched polarity bit (0 = low, 1 = high). It returns to that level after each transfer.
- R2: With phase bit 0, the first data bit is on `mosi` before the first clock edge, and both sides sample on every leading edge. With phase bit 1, data changes on the leading edge and is sampled on the trailing edge.
- R3: `ctl_lsb_first` = 0 shifts the bit at position length-1 first, and 1 shifts bit 0 first. This order applies to both directions. Parallel words stay right-justified in both orders.
- R4: A length field below 2 acts as 2, and a value above 16 acts as 16. Each transfer makes exactly 2×length clock edges.
- R5: Receive bits at and above the length read as zero. Transmit bits at and above the length are never sent.
- R6: A transmit write starts a transfer only when the engine is enabled and idle. Writes while busy or while disabled have no effect.
- R7: `ss_n` goes low one half-period before the first clock edge. It goes high one half-period after the last edge.
- R8: `done` is high for exactly one cycle per transfer, once the final bit has been sampled. `complete` is set with it and stays set until `rx_re` clears it.
- R9: Polarity, phase, order and length are taken from a control write only if the engine is disabled, idle, and the write keeps enable clear. Otherwise they are ignored, and the enable bit still follows the write.
- R10: After reset, `ss_n` is high, `sclk` is low, and `busy`, `done`, `complete` and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value for the control write |
| ctl_cpol | input | 1 | Clock idle level for the control write |
| ctl_cpha | input | 1 | Clock phase for the control write |
| ctl_lsb_first | input | 1 | Shift order for the control write (1 = bit 0 first) |
| ctl_len | input | 5 | Word length for the control write |
| tx_we | input | 1 | Transmit word write strobe |
| tx_data | input | 16 | Transmit word, right-justified |
| rx_re | input | 1 | Receive word read strobe, clears `complete` |
| rx_data | output | 16 | Last received word, right-justified, upper bits zero |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| complete | output | 1 | Sticky transfer-complete flag |

## Verification
A bench slave exchanges words with the engine in all four clock modes, at lengths 2, 5, 8, 12 and 16, and in both shift orders. Each direction uses an asymmetric word, so a mirrored bit order or a sample on the wrong edge shows up as a different value. Length fields of 0 and 31 tell the clamp apart from truncation. All-ones words at a short length catch upper bits that leak through. Control writes that combine an enable change with a new polarity or length, and transmit writes issued while busy or disabled, show whether the guarded settings and start condition hold.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int unsigned WORD_MAX = 16;
    localparam int unsigned WORD_MIN = 2;
    localparam int unsigned LEN_W    = $clog2(WORD_MAX + 1);
    localparam int unsigned IDX_W    = $clog2(WORD_MAX);
    localparam int unsigned EDGE_W   = LEN_W + 1;

    typedef enum logic {XF_IDLE, XF_RUN} xfer_st_e;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic             lsb_first;
        logic [LEN_W-1:0] len;
    } spi_mode_t;

    typedef struct packed {
        logic      en;
        spi_mode_t mode;
    } spi_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(WORD_MIN)) return LEN_W'(WORD_MIN);
        if (raw > LEN_W'(WORD_MAX)) return LEN_W'(WORD_MAX);
        return raw;
    endfunction

    // position in the parallel word of the k-th bit on the wire
    function automatic logic [IDX_W-1:0] wire_pos(input logic [LEN_W-1:0] len,
                                                  input logic lsb_first,
                                                  input logic [LEN_W-1:0] k);
        logic [LEN_W-1:0] p;
        p = lsb_first ? k : (len - LEN_W'(1) - k);
        return p[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/spi_mode_reg.sv
module spi_mode_reg
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic             wr_cpol,
    input  logic             wr_cpha,
    input  logic             wr_lsb_first,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             busy,
    output logic             en,
    output spi_mode_t        mode
);

    spi_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.en = wr_en;
            if (!cfg_q.en && !wr_en && !busy) begin
                cfg_d.mode.cpol      = wr_cpol;
                cfg_d.mode.cpha      = wr_cpha;
                cfg_d.mode.lsb_first = wr_lsb_first;
                cfg_d.mode.len       = clamp_len(wr_len);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en             <= 1'b0;
            cfg_q.mode.cpol      <= 1'b0;
            cfg_q.mode.cpha      <= 1'b0;
            cfg_q.mode.lsb_first <= 1'b0;
            cfg_q.mode.len       <= LEN_W'(8);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en   = cfg_q.en;
    assign mode = cfg_q.mode;

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int unsigned HALF_PERIOD_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    if (HALF_PERIOD_CLKS <= 1) begin : g_direct
        assign tick = run;
    end else begin : g_count
        localparam int unsigned CW = $clog2(HALF_PERIOD_CLKS);
        localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD_CLKS - 1);

        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (!run || cnt_q == LAST) cnt_d = '0;
            else                       cnt_d = cnt_q + CW'(1);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign tick = run && (cnt_q == LAST);
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int unsigned HALF_PERIOD_CLKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                ctl_enable,
    input  logic                ctl_cpol,
    input  logic                ctl_cpha,
    input  logic                ctl_lsb_first,
    input  logic [LEN_W-1:0]    ctl_len,
    input  logic                tx_we,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                rx_re,
    output logic [WORD_MAX-1:0] rx_data,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                ss_n,
    output logic                busy,
    output logic                done,
    output logic                complete
);

    typedef struct packed {
        xfer_st_e            st;
        logic [EDGE_W-1:0]   ecnt;
        logic [WORD_MAX-1:0] txw;
        logic [WORD_MAX-1:0] acc;
        logic [WORD_MAX-1:0] rxw;
        logic                sclk;
        logic                mosi;
        logic                ss_n;
        logic                done;
        logic                cmpl;
    } core_t;

    core_t     core_d, core_q;
    logic      cur_en;
    spi_mode_t cur_mode;
    logic      tick;

    spi_mode_reg u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (ctl_we),
        .wr_en        (ctl_enable),
        .wr_cpol      (ctl_cpol),
        .wr_cpha      (ctl_cpha),
        .wr_lsb_first (ctl_lsb_first),
        .wr_len       (ctl_len),
        .busy         (busy),
        .en           (cur_en),
        .mode         (cur_mode)
    );

    spi_half_tick #(.HALF_PERIOD_CLKS(HALF_PERIOD_CLKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    logic [WORD_MAX-1:0] len_mask;
    logic [EDGE_W-1:0]   edge_total;
    logic [LEN_W-1:0]    bit_k;
    logic [IDX_W-1:0]    pos_k, pos_next;
    logic                is_sample;

    always_comb begin
        len_mask   = {WORD_MAX{1'b1}} >> (LEN_W'(WORD_MAX) - cur_mode.len);
        edge_total = {cur_mode.len, 1'b0};
        bit_k      = core_q.ecnt[EDGE_W-1:1];
        pos_k      = wire_pos(cur_mode.len, cur_mode.lsb_first, bit_k);
        pos_next   = wire_pos(cur_mode.len, cur_mode.lsb_first, bit_k + LEN_W'(1));
        is_sample  = (core_q.ecnt[0] == cur_mode.cpha);

        core_d      = core_q;
        core_d.done = 1'b0;
        if (rx_re) core_d.cmpl = 1'b0;

        unique case (core_q.st)
            XF_IDLE: begin
                core_d.sclk = cur_mode.cpol;
                core_d.ss_n = 1'b1;
                if (tx_we && cur_en) begin
                    core_d.st   = XF_RUN;
                    core_d.ecnt = '0;
                    core_d.txw  = tx_data & len_mask;
                    core_d.acc  = '0;
                    core_d.ss_n = 1'b0;
                    if (!cur_mode.cpha)
                        core_d.mosi = tx_data[wire_pos(cur_mode.len, cur_mode.lsb_first, '0)];
                end
            end
            XF_RUN: begin
                if (tick) begin
                    if (core_q.ecnt == edge_total) begin
                        core_d.st   = XF_IDLE;
                        core_d.ss_n = 1'b1;
                    end else begin
                        core_d.sclk = ~core_q.sclk;
                        core_d.ecnt = core_q.ecnt + EDGE_W'(1);
                        if (is_sample) begin
                            core_d.acc[pos_k] = miso;
                            if (bit_k == cur_mode.len - LEN_W'(1)) begin
                                core_d.rxw  = core_d.acc;
                                core_d.done = 1'b1;
                                core_d.cmpl = 1'b1;
                            end
                        end else if (cur_mode.cpha) begin
                            core_d.mosi = core_q.txw[pos_k];
                        end else if ((bit_k + LEN_W'(1)) < cur_mode.len) begin
                            core_d.mosi = core_q.txw[pos_next];
                        end
                    end
                end
            end
            default: core_d.st = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.st   <= XF_IDLE;
            core_q.ecnt <= '0;
            core_q.txw  <= '0;
            core_q.acc  <= '0;
            core_q.rxw  <= '0;
            core_q.sclk <= 1'b0;
            core_q.mosi <= 1'b0;
            core_q.ss_n <= 1'b1;
            core_q.done <= 1'b0;
            core_q.cmpl <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy     = (core_q.st == XF_RUN);
    assign rx_data  = core_q.rxw;
    assign sclk     = core_q.sclk;
    assign mosi     = core_q.mosi;
    assign ss_n     = core_q.ss_n;
    assign done     = core_q.done;
    assign complete = core_q.cmpl;

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk
    import spi_eng_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sclk,
    input logic      ss_n,
    input logic      busy,
    input logic      done,
    input logic      complete,
    input logic      rx_re,
    input logic      en,
    input spi_mode_t mode
);

    logic              sclk_prev;
    logic [EDGE_W:0]   edge_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            edge_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (!busy)                 edge_cnt <= '0;
            else if (sclk != sclk_prev) edge_cnt <= edge_cnt + 1'b1;
        end
    end

    a_r1_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && $past(ss_n) && $past(mode.cpol) == mode.cpol) |-> sclk == mode.cpol);

    a_r4_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> edge_cnt == (EDGE_W + 1)'({mode.len, 1'b0}));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> complete);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_re |=> (!complete || done));

    a_r9_frozen_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(mode));

    a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));

endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .busy     (busy),
    .done     (done),
    .complete (complete),
    .rx_re    (rx_re),
    .en       (cur_en),
    .mode     (cur_mode)
);

// File: tb/sim_spi_shift_engine.sv
`timescale 1ns/1ps
module sim_spi_shift_engine;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_enable = 1'b0, ctl_cpol = 1'b0, ctl_cpha = 1'b0, ctl_lsb_first = 1'b0;
    logic [4:0]  ctl_len = 5'd8;
    logic        tx_we = 1'b0;
    logic [15:0] tx_data = '0;
    logic        rx_re = 1'b0;
    logic [15:0] rx_data;
    logic        miso = 1'b0;
    logic        sclk, mosi, ss_n, busy, done, complete;

    int n_chk = 0;
    int n_fail = 0;

    // effective settings the bench slave uses
    int   s_len = 8;
    logic s_cpha = 1'b0, s_lsb = 1'b0, s_cpol = 1'b0;
    logic [15:0] s_word = '0;

    // slave monitor state
    int cyc = 0, edges = 0, ks = 0, ko = 0, done_cnt = 0;
    int t_ss = 0, t_first = 0, t_last = 0, t_rise = 0;
    logic [15:0] cap_word = '0;
    logic prev_ss = 1'b1, prev_sclk = 1'b0;

    always #10 clk = ~clk;

    spi_shift_engine #(.HALF_PERIOD_CLKS(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .ctl_cpol(ctl_cpol), .ctl_cpha(ctl_cpha), .ctl_lsb_first(ctl_lsb_first),
        .ctl_len(ctl_len), .tx_we(tx_we), .tx_data(tx_data), .rx_re(rx_re),
        .rx_data(rx_data), .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .busy(busy), .done(done), .complete(complete)
    );

    function automatic int wpos(input int k);
        return s_lsb ? k : (s_len - 1 - k);
    endfunction

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (done === 1'b1) done_cnt = done_cnt + 1;
        if (prev_ss && ss_n === 1'b0) begin
            t_ss = cyc; edges = 0; ks = 0; ko = 0; cap_word = '0;
            if (!s_cpha) begin miso = s_word[wpos(0)]; ko = 1; end
        end
        if (ss_n === 1'b0 && sclk !== prev_sclk) begin
            if (edges == 0) t_first = cyc;
            t_last = cyc;
            if ((edges % 2 == 0) == !s_cpha) begin
                if (ks < s_len) cap_word[wpos(ks)] = mosi;
                ks = ks + 1;
            end else begin
                if (ko < s_len) miso = s_word[wpos(ko)];
                ko = ko + 1;
            end
            edges = edges + 1;
        end
        if (!prev_ss && ss_n === 1'b1) t_rise = cyc;
        prev_ss   = ss_n;
        prev_sclk = sclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic en, input logic cpol, input logic cpha,
                             input logic lsb, input logic [4:0] len);
        @(negedge clk);
        ctl_we = 1'b1; ctl_enable = en; ctl_cpol = cpol; ctl_cpha = cpha;
        ctl_lsb_first = lsb; ctl_len = len;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic set_mode(input logic cpol, input logic cpha, input logic lsb,
                            input logic [4:0] len, input int eff_len);
        ctl_write(1'b0, cpol, cpha, lsb, len);
        ctl_write(1'b0, cpol, cpha, lsb, len);
        ctl_write(1'b1, cpol, cpha, lsb, len);
        s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_len = eff_len;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_re = 1'b1;
        @(negedge clk); rx_re = 1'b0;
        @(negedge clk);
        check("R8 complete cleared by read", {31'd0, complete}, 32'd1 ^ 32'd1);
    endtask

    task automatic xfer(input logic [15:0] tx, input logic [15:0] sw, input bit poke_busy);
        logic [15:0] mask;
        int guard;
        mask = 16'hFFFF >> (16 - s_len);
        s_word = sw; done_cnt = 0;
        @(negedge clk); tx_we = 1'b1; tx_data = tx;
        @(negedge clk); tx_we = 1'b0;
        check("R6 transfer starts", {31'd0, busy}, 32'd1);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            tx_we = 1'b1; tx_data = ~tx;
            @(negedge clk); tx_we = 1'b0;
        end
        guard = 0;
        while (busy === 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
        check("R3 rx word right-justified", {16'd0, rx_data}, {16'd0, sw & mask});
        check("R5 rx upper bits zero", {16'd0, rx_data & ~mask}, 32'd0);
        check("R2 mosi word seen by slave", {16'd0, cap_word}, {16'd0, tx & mask});
        check("R4 edge count", edges, 2 * s_len);
        check("R7 select lead time", t_first - t_ss, HALF);
        check("R7 select trail time", t_rise - t_last, HALF);
        check("R8 single done pulse", done_cnt, 1);
        check("R8 complete flag", {31'd0, complete}, 32'd1);
        check("R1 sclk back at idle", {31'd0, sclk}, {31'd0, s_cpol});
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            check("R6 busy write ignored", {31'd0, busy}, 32'd0);
        end
        read_rx();
    endtask

    task automatic t_reset();
        check("R10 ss_n", {31'd0, ss_n}, 32'd1);
        check("R10 sclk", {31'd0, sclk}, 32'd0);
        check("R10 busy", {31'd0, busy}, 32'd0);
        check("R10 done/complete", {30'd0, done, complete}, 32'd0);
        check("R10 rx_data", {16'd0, rx_data}, 32'd0);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0], 1'b0, 5'd8, 8);
            check("R1 idle level per mode", {31'd0, sclk}, {31'd0, s_cpol});
            xfer(16'h00B4 ^ 16'(m), 16'h0039 + 16'(m * 3), 1'b0);
        end
    endtask

    task automatic t_order();
        set_mode(1'b0, 1'b1, 1'b1, 5'd12, 12);
        xfer(16'h0C35, 16'h05A3, 1'b0);
        set_mode(1'b1, 1'b0, 1'b1, 5'd12, 12);
        xfer(16'h0E01, 16'h0813, 1'b0);
        set_mode(1'b0, 1'b0, 1'b0, 5'd12, 12);
        xfer(16'h0C35, 16'h05A3, 1'b0);
    endtask

    task automatic t_lengths();
        set_mode(1'b0, 1'b0, 1'b0, 5'd16, 16);
        xfer(16'h8137, 16'hC00B, 1'b0);
        set_mode(1'b1, 1'b1, 1'b1, 5'd2, 2);
        xfer(16'h0001, 16'h0002, 1'b0);
        set_mode(1'b0, 1'b1, 1'b0, 5'd0, 2);
        xfer(16'hFFF2, 16'hFFF1, 1'b0);
        set_mode(1'b1, 1'b0, 1'b1, 5'd31, 16);
        xfer(16'h4A1F, 16'h90E6, 1'b0);
        set_mode(1'b0, 1'b0, 1'b0, 5'd5, 5);
        xfer(16'hFFE3, 16'hFFFF, 1'b0);
    endtask

    task automatic t_busy_and_disabled();
        set_mode(1'b0, 1'b0, 1'b0, 5'd8, 8);
        xfer(16'h00C6, 16'h0071, 1'b1);
        ctl_write(1'b0, 1'b0, 1'b0, 1'b0, 5'd8);
        @(negedge clk); tx_we = 1'b1; tx_data = 16'h0055;
        @(negedge clk); tx_we = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 disabled write ignored busy", {31'd0, busy}, 32'd0);
        check("R6 disabled write ignored ss_n", {31'd0, ss_n}, 32'd1);
    endtask

    task automatic t_lock();
        set_mode(1'b0, 1'b0, 1'b0, 5'd8, 8);
        ctl_write(1'b1, 1'b1, 1'b0, 1'b0, 5'd4);
        @(negedge clk);
        check("R9 polarity ignored while enabled", {31'd0, sclk}, 32'd0);
        xfer(16'h009D, 16'h0062, 1'b0);
        ctl_write(1'b0, 1'b1, 1'b0, 1'b0, 5'd8);
        @(negedge clk);
        check("R9 polarity ignored with enable change", {31'd0, sclk}, 32'd0);
        ctl_write(1'b0, 1'b1, 1'b0, 1'b0, 5'd8);
        @(negedge clk);
        check("R9 polarity taken while disabled", {31'd0, sclk}, 32'd1);
        ctl_write(1'b1, 1'b0, 1'b0, 1'b0, 5'd8);
        @(negedge clk);
        check("R9 polarity ignored on enabling write", {31'd0, sclk}, 32'd1);
        s_cpol = 1'b1;
        xfer(16'h0017, 16'h00E8, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_order();
        t_lengths();
        t_busy_and_disabled();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule